// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

This block is a simple dual-port memory built around a fixed array of 4,608 bits. One port only writes and the other only reads. Both run on the same clock, and each can be active in any cycle without regard to the other. Each port takes its own 3-bit shape code, which chooses one of five depth-by-width views of the same storage: 4096×1, 2048×2, 1024×4, 512×9 or 256×18. Data stored through one view can be read back through another. For example, nibbles written four bits at a time can be read back one bit per address as a serial stream.

Internally the storage is arranged as 512 lanes of 9 bits. The 9-bit and 18-bit views cover every bit of the array. The 1-, 2- and 4-bit views cover only the low eight bits of each lane, which gives a 4,096-bit packed space. In that space, lower addresses land on lower bit positions. A read is registered and its result appears one cycle after it is requested. When the read port is idle, the previous result stays on the output.

Top module: `mixed_width_ram`

## Requirements
- R1: A synchronous active-high reset drives rd_data to zero. The first valid read after reset returns stored data, and the stored contents are not cleared by reset.
- R2: Shape codes are 0 = 4096×1, 1 = 2048×2, 2 = 1024×4, 3 = 512×9 and 4 = 256×18. Codes 5, 6 and 7 behave as 4096×1. Address bits above those the chosen shape needs (12, 11, 10, 9 or 8 bits respectively) are ignored.
- R3: In the 18-bit shape, address A covers lane 2A in data[8:0] and lane 2A+1 in data[17:9]. In the 9-bit shape, address A covers lane A in data[8:0].
- R4: In a shape of width w ∈ {1,2,4}, address N covers packed bits N·w to N·w+w−1, with address bit 0 the least significant. Packed bit p is bit p mod 8 of lane p/8. Bit 8 of a lane is never changed by a write in these shapes.
- R5: Nibbles written in the 4-bit shape and then read in the 1-bit shape come back least-significant bit first, one bit per address, starting at address 4N for nibble N.
- R6: A read in a shape narrower than 18 bits places its data in the low bits of rd_data, and all bits above the shape's width are zero.
- R7: Data read with rd_en high at one rising edge is on rd_data after that edge, and it reflects every write completed at earlier edges.
- R8: While rd_en is low, rd_data keeps its value.
- R9: A read and a write to overlapping bits at the same edge return the data held before that write. The write still takes effect for later reads.
- R10: While wr_en is low, the write address and data have no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read output |
| wr_en | input | 1 | Write enable |
| wr_mode | input | 3 | Write-port shape code |
| wr_addr | input | 12 | Write address, in units of the write shape |
| wr_data | input | 18 | Write data, low bits used in narrow shapes |
| rd_en | input | 1 | Read enable |
| rd_mode | input | 3 | Read-port shape code |
| rd_addr | input | 12 | Read address, in units of the read shape |
| rd_data | output | 18 | Read data, one cycle after the request |

## Verification
A write and a read can fall on the same edge, and they can hit the same lane while using different shapes. That case is the read-during-write collision. The bench provokes it in two ways. It drives both ports at the same address in one shape, and it drives random address pairs where the two shapes differ and the bits partly overlap. A behavioural lane model judges each cycle. The model computes the read before it applies the write, so any cycle where the new value leaks through is flagged against R9.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  localparam int LANE_W = 9;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 2 * LANE_W;
  localparam int IDX_W  = 8;
  localparam int OFF_W  = 3;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_X1  = 3'd0;
  localparam logic [MODE_W-1:0] MODE_X2  = 3'd1;
  localparam logic [MODE_W-1:0] MODE_X4  = 3'd2;
  localparam logic [MODE_W-1:0] MODE_X9  = 3'd3;
  localparam logic [MODE_W-1:0] MODE_X18 = 3'd4;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             bank;
    logic [OFF_W-1:0] off;
  } loc_t;

  // Map a port address to bank row, bank select and bit offset in the lane.
  function automatic loc_t map_addr(input logic [MODE_W-1:0] mode,
                                    input logic [ADDR_W-1:0] a);
    loc_t l;
    l = '0;
    case (mode)
      MODE_X18: l.idx = a[IDX_W-1:0];
      MODE_X9: begin
        l.idx  = a[IDX_W:1];
        l.bank = a[0];
      end
      MODE_X4: begin
        l.idx  = a[IDX_W+1:2];
        l.bank = a[1];
        l.off  = {a[0], 2'b00};
      end
      MODE_X2: begin
        l.idx  = a[IDX_W+2:3];
        l.bank = a[2];
        l.off  = {a[1:0], 1'b0};
      end
      default: begin
        l.idx  = a[IDX_W+3:4];
        l.bank = a[3];
        l.off  = a[2:0];
      end
    endcase
    return l;
  endfunction

  // Unshifted bit mask of one access within a lane.
  function automatic logic [LANE_W-1:0] width_mask(input logic [MODE_W-1:0] mode);
    case (mode)
      MODE_X18, MODE_X9: return {LANE_W{1'b1}};
      MODE_X4:           return LANE_W'(4'hF);
      MODE_X2:           return LANE_W'(2'h3);
      default:           return LANE_W'(1'b1);
    endcase
  endfunction

endpackage

// File: rtl/mwr_bank.sv
module mwr_bank #(
  parameter int LANE_W = 9,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LANE_W-1:0] wmask,
  input  logic [LANE_W-1:0] wdin,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [LANE_W-1:0] q
);

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[widx] <= (mem[widx] & ~wmask) | (wdin & wmask);
  end

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (re)
      q <= mem[ridx];
  end

endmodule

// File: rtl/mwr_wr_map.sv
module mwr_wr_map
  import mwr_pkg::*;
(
  input  logic                   en,
  input  logic [MODE_W-1:0]      mode,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      data,
  output logic [1:0]             we,
  output logic [IDX_W-1:0]       idx,
  output logic [1:0][LANE_W-1:0] mask,
  output logic [1:0][LANE_W-1:0] din
);

  loc_t              loc;
  logic [LANE_W-1:0] m;

  always_comb begin
    loc = map_addr(mode, addr);
    idx = loc.idx;
    m   = width_mask(mode) << loc.off;
    if (mode == MODE_X18) begin
      we      = {en, en};
      mask[0] = {LANE_W{1'b1}};
      mask[1] = {LANE_W{1'b1}};
      din[0]  = data[LANE_W-1:0];
      din[1]  = data[DATA_W-1:LANE_W];
    end else begin
      we      = en ? (loc.bank ? 2'b10 : 2'b01) : 2'b00;
      mask[0] = m;
      mask[1] = m;
      din[0]  = data[LANE_W-1:0] << loc.off;
      din[1]  = data[LANE_W-1:0] << loc.off;
    end
  end

endmodule

// File: rtl/mwr_rd_align.sv
module mwr_rd_align
  import mwr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic [MODE_W-1:0]      mode,
  input  logic [ADDR_W-1:0]      addr,
  output logic [IDX_W-1:0]       idx,
  input  logic [1:0][LANE_W-1:0] q,
  output logic [DATA_W-1:0]      rd_data
);

  loc_t              loc;
  logic [MODE_W-1:0] mode_q;
  logic              bank_q;
  logic [OFF_W-1:0]  off_q;
  logic [LANE_W-1:0] lane;
  logic [LANE_W-1:0] sh;

  always_comb begin
    loc = map_addr(mode, addr);
    idx = loc.idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_X18;
      bank_q <= 1'b0;
      off_q  <= '0;
    end else if (en) begin
      mode_q <= mode;
      bank_q <= loc.bank;
      off_q  <= loc.off;
    end
  end

  always_comb begin
    lane = bank_q ? q[1] : q[0];
    sh   = lane >> off_q;
    if (mode_q == MODE_X18)
      rd_data = {q[1], q[0]};
    else
      rd_data = DATA_W'(sh & width_mask(mode_q));
  end

endmodule

// File: rtl/mixed_width_ram.sv
module mixed_width_ram
  import mwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_mode,
  input  logic [11:0]       wr_addr,
  input  logic [17:0]       wr_data,
  input  logic              rd_en,
  input  logic [2:0]        rd_mode,
  input  logic [11:0]       rd_addr,
  output logic [17:0]       rd_data
);

  localparam int BANKS = 2;
  localparam int DEPTH = 1 << IDX_W;

  logic [BANKS-1:0]             bwe;
  logic [IDX_W-1:0]             widx;
  logic [IDX_W-1:0]             ridx;
  logic [BANKS-1:0][LANE_W-1:0] bmask;
  logic [BANKS-1:0][LANE_W-1:0] bdin;
  logic [BANKS-1:0][LANE_W-1:0] bq;

  mwr_wr_map u_wmap (
    .en   (wr_en),
    .mode (wr_mode),
    .addr (wr_addr),
    .data (wr_data),
    .we   (bwe),
    .idx  (widx),
    .mask (bmask),
    .din  (bdin)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    mwr_bank #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (bwe[b]),
      .widx  (widx),
      .wmask (bmask[b]),
      .wdin  (bdin[b]),
      .re    (rd_en),
      .ridx  (ridx),
      .q     (bq[b])
    );
  end

  mwr_rd_align u_ralign (
    .clk     (clk),
    .rst     (rst),
    .en      (rd_en),
    .mode    (rd_mode),
    .addr    (rd_addr),
    .idx     (ridx),
    .q       (bq),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/mixed_width_ram_chk.sv
module mixed_width_ram_chk
  import mwr_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic [2:0]  rd_mode,
  input logic [17:0] rd_data
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> rd_data == '0);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_en) && !$past(rst)) |-> $stable(rd_data));

  // R6
  x9_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst) && $past(rd_mode) == MODE_X9) |-> rd_data[17:9] == '0);

  // R6
  x4_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst) && $past(rd_mode) == MODE_X4) |-> rd_data[17:4] == '0);

  // R6
  x2_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst) && $past(rd_mode) == MODE_X2) |-> rd_data[17:2] == '0);

  // R6, R2
  x1_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_en) && !$past(rst) &&
     ($past(rd_mode) == MODE_X1 || $past(rd_mode) > MODE_X18)) |-> rd_data[17:1] == '0);

endmodule

bind mixed_width_ram mixed_width_ram_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .rd_en   (rd_en),
  .rd_mode (rd_mode),
  .rd_data (rd_data)
);

// File: tb/mixed_width_ram_test.sv
module mixed_width_ram_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_mode = '0;
  logic [11:0] wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_mode = '0;
  logic [11:0] rd_addr = '0;
  logic [17:0] rd_data;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  logic [8:0]  ref_lane [512];
  logic [17:0] exp_q = '0;

  mixed_width_ram uut (.*);

  always #4 clk = ~clk;

  function automatic int width_of(input logic [2:0] m);
    if (m == 3'd1) return 2;
    if (m == 3'd2) return 4;
    return 1;
  endfunction

  function automatic logic [17:0] model_read(input logic [2:0] m, input logic [11:0] a);
    logic [17:0] r;
    r = '0;
    if (m == 3'd4) begin
      r = {ref_lane[2*int'(a[7:0])+1], ref_lane[2*int'(a[7:0])]};
    end else if (m == 3'd3) begin
      r[8:0] = ref_lane[int'(a[8:0])];
    end else begin
      int w = width_of(m);
      int n = int'(a) % (4096 / w);
      for (int i = 0; i < w; i++) begin
        int p = n * w + i;
        r[i] = ref_lane[p / 8][p % 8];
      end
    end
    return r;
  endfunction

  task automatic model_write(input logic [2:0] m, input logic [11:0] a, input logic [17:0] d);
    if (m == 3'd4) begin
      ref_lane[2*int'(a[7:0])]   = d[8:0];
      ref_lane[2*int'(a[7:0])+1] = d[17:9];
    end else if (m == 3'd3) begin
      ref_lane[int'(a[8:0])] = d[8:0];
    end else begin
      int w = width_of(m);
      int n = int'(a) % (4096 / w);
      for (int i = 0; i < w; i++) begin
        int p = n * w + i;
        ref_lane[p / 8][p % 8] = d[i];
      end
    end
  endtask

  // Reference model: read sees contents before this edge's write (R7, R9)
  always @(posedge clk) begin
    if (rst) exp_q = '0;
    else begin
      if (rd_en) exp_q = model_read(rd_mode, rd_addr);
      if (wr_en) model_write(wr_mode, wr_addr, wr_data);
    end
  end

  task automatic expect_eq(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    expect_eq(cur_req, rd_data, exp_q);
  endtask

  task automatic op(input logic we, input logic [2:0] wm, input logic [11:0] wa,
                    input logic [17:0] wd, input logic re, input logic [2:0] rm,
                    input logic [11:0] ra);
    wr_en = we; wr_mode = wm; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_mode = rm; rd_addr = ra;
    tick();
  endtask

  task automatic idle();
    op(1'b0, 3'd0, '0, '0, 1'b0, 3'd0, '0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected=finish");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1: reset state
    cur_req = "R1";
    expect_eq("R1", rd_data, 18'h0);
    tick();
    rst = 1'b0;

    // R3: fill every lane through the 18-bit shape
    cur_req = "R3";
    for (int a = 0; a < 256; a++)
      op(1'b1, 3'd4, 12'(a), 18'($urandom), 1'b0, 3'd0, '0);
    for (int a = 0; a < 256; a++)
      op(1'b0, 3'd0, '0, '0, 1'b1, 3'd4, 12'(a));
    idle();
    for (int a = 0; a < 512; a++)
      op(1'b0, 3'd0, '0, '0, 1'b1, 3'd3, 12'(a));
    // R3: 9-bit write, 18-bit read with explicit value
    op(1'b1, 3'd3, 12'd20, 18'h0_0155, 1'b0, 3'd0, '0);
    op(1'b1, 3'd3, 12'd21, 18'h0_00AA, 1'b0, 3'd0, '0);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd4, 12'd10);
    expect_eq("R3", rd_data, {9'h0AA, 9'h155});
    idle();

    // R4, R6: narrow views of the packed space
    cur_req = "R4";
    for (int a = 0; a < 64; a++) op(1'b0, 3'd0, '0, '0, 1'b1, 3'd2, 12'(a));
    idle();
    for (int a = 0; a < 64; a++) op(1'b0, 3'd0, '0, '0, 1'b1, 3'd1, 12'(a));
    idle();
    cur_req = "R6";
    for (int a = 0; a < 64; a++) op(1'b0, 3'd0, '0, '0, 1'b1, 3'd0, 12'(a));
    idle();
    // R4: narrow writes leave lane bit 8 alone
    cur_req = "R4";
    op(1'b1, 3'd3, 12'd40, 18'h1FF, 1'b0, 3'd0, '0);
    op(1'b1, 3'd2, 12'd80, 18'h3FFF0, 1'b0, 3'd0, '0);
    op(1'b1, 3'd2, 12'd81, 18'h00005, 1'b0, 3'd0, '0);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd3, 12'd40);
    expect_eq("R4", rd_data, 18'h150);
    idle();

    // R5: nibbles in, serial bits out
    cur_req = "R5";
    for (int k = 0; k < 16; k++)
      op(1'b1, 3'd2, 12'(100 + k), 18'((k * 7) & 15), 1'b0, 3'd0, '0);
    idle();
    for (int b = 0; b < 64; b++) begin
      op(1'b0, 3'd0, '0, '0, 1'b1, 3'd0, 12'(400 + b));
      expect_eq("R5", rd_data, 18'((((b / 4) * 7 & 15) >> (b % 4)) & 1));
    end
    idle();
    // R4: serial bits in, nibble out
    cur_req = "R4";
    for (int b = 0; b < 8; b++)
      op(1'b1, 3'd0, 12'(2000 + b), 18'((8'hC6 >> b) & 1), 1'b0, 3'd0, '0);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd2, 12'd500);
    expect_eq("R4", rd_data, 18'h6);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd2, 12'd501);
    expect_eq("R4", rd_data, 18'hC);
    idle();

    // R8: reads idle while writes proceed
    cur_req = "R8";
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd4, 12'd33);
    for (int i = 0; i < 20; i++)
      op(1'b1, 3'd4, 12'd33, 18'($urandom), 1'b0, 3'($urandom % 5), 12'($urandom));

    // R9: same-edge read and write
    cur_req = "R9";
    op(1'b1, 3'd3, 12'd7, 18'h0AB, 1'b0, 3'd0, '0);
    op(1'b1, 3'd3, 12'd7, 18'h154, 1'b1, 3'd3, 12'd7);
    expect_eq("R9", rd_data, 18'h0AB);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd3, 12'd7);
    expect_eq("R9", rd_data, 18'h154);
    for (int i = 0; i < 60; i++) begin
      logic [11:0] a = 12'($urandom);
      logic [2:0]  m = 3'($urandom % 5);
      op(1'b1, m, a, 18'($urandom), 1'b1, m, a);
    end
    for (int i = 0; i < 60; i++) begin
      logic [11:0] a = 12'($urandom % 64);
      op(1'b1, 3'($urandom % 5), a, 18'($urandom), 1'b1, 3'($urandom % 5), a);
    end
    idle();

    // R10: disabled writes change nothing
    cur_req = "R10";
    for (int i = 0; i < 30; i++) begin
      logic [11:0] a = 12'($urandom);
      logic [2:0]  m = 3'($urandom % 5);
      op(1'b0, m, a, 18'($urandom), 1'b0, 3'd0, '0);
      op(1'b0, m, a, 18'($urandom), 1'b1, m, a);
    end
    idle();

    // R2: reserved codes and ignored upper address bits
    cur_req = "R2";
    op(1'b1, 3'd5, 12'd3000, 18'h3FFFF, 1'b0, 3'd0, '0);
    op(1'b1, 3'd6, 12'd3001, 18'h0, 1'b0, 3'd0, '0);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd7, 12'd3000);
    expect_eq("R2", rd_data, 18'h1);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd0, 12'd3001);
    expect_eq("R2", rd_data, 18'h0);
    op(1'b1, 3'd4, 12'hF05, 18'h2468A, 1'b0, 3'd0, '0);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd4, 12'h005);
    expect_eq("R2", rd_data, 18'h2468A);
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd3, 12'hE0A);
    expect_eq("R2", rd_data, 18'h08A);
    idle();

    // R7: mixed random traffic compared each cycle
    cur_req = "R7";
    for (int s = 0; s < 10; s++) begin
      logic [2:0] wm = 3'($urandom % 8);
      logic [2:0] rm = 3'($urandom % 8);
      for (int i = 0; i < 100; i++)
        op(1'($urandom), wm, 12'($urandom), 18'($urandom), 1'($urandom), rm, 12'($urandom));
      idle();
    end

    // R1: reset mid-run clears output but keeps contents
    cur_req = "R1";
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd4, 12'd10);
    rst = 1'b1;
    idle();
    expect_eq("R1", rd_data, 18'h0);
    rst = 1'b0;
    op(1'b0, 3'd0, '0, '0, 1'b1, 3'd4, 12'd10);
    idle();

    finish_run();
  end

endmodule